// File: doc/BRIEF.md
# Low-Power Clock Source Controller

This block chooses which clock drives the system, gates the clock output pin and the peripheral E-clock, and switches between clock sources when the device enters or leaves a low-power stop. A mode pin is sampled while reset is held, and the sampled value is kept. It selects one of two schemes. The synthesizer scheme runs from a VCO that is locked to a reference. The direct scheme runs straight from an external clock. In the synthesizer scheme, one stop control bit decides whether the VCO keeps running during stop or whether the system falls back to the reference. A second bit decides whether the output clocks keep toggling during stop.

A control clock runs the logic. It oversamples the three source clocks, so every source change can wait for the outgoing clock and then the incoming clock to be low. After the VCO has been off, a relock delay counted in reference edges must expire before the VCO is switched back in. A monitor counts VCO edges between reference edges. When the reference is lost, the monitor sets a sticky limp flag. It then either forces limp mode or raises a device reset request, according to a reset-on-loss input.

The control state machine has these states:
- `ST_INIT`: just after reset, with all clocks gated.
- `ST_RELOCK`: the VCO is enabled and the system runs on the reference while the relock delay counts.
- `ST_RUN`: normal operation.
- `ST_SW_OFF`: waiting for the old source to be low, then gating it off.
- `ST_SW_ON`: waiting for the new source to be low, then selecting it and ungating.
- `ST_STOP`: low-power stop.

Its transitions are:
- `ST_INIT` goes to `ST_SW_OFF` on the first cycle after reset.
- `ST_RELOCK` goes to `ST_SW_OFF` when lock is valid.
- `ST_RUN` goes to `ST_SW_OFF` on a stop request.
- `ST_STOP` goes to `ST_SW_OFF` on a wake.
- `ST_SW_OFF` goes to `ST_SW_ON` when the old source is low.
- `ST_SW_ON` goes to the stored return state (`ST_RUN`, `ST_STOP` or `ST_RELOCK`) when the new source is low.

Top module: `lpc_clk_ctrl`

## Requirements
- R1: The mode pin is captured while rst_n is low, and only that captured value selects the scheme. Changing the pin after reset has no effect on which clock drives sys_clk.
- R2: With captured mode 1 (direct scheme), sys_clk follows ext_clk in run and in stop for every setting of the stop bits, and vco_en stays 0.
- R3: With captured mode 0 in run, once settled, sys_clk follows vco_clk and both vco_en and lock_ok are 1.
- R4: With captured mode 0 in stop, stop_sys_vco=0 makes sys_clk follow ref_clk with vco_en=0. stop_sys_vco=1 keeps sys_clk on vco_clk with vco_en=1. The stop bits are taken at the stop request.
- R5: In run, clk_out and e_clk equal sys_clk. In stop they equal sys_clk when stop_out_en=1 and are held at 0 when stop_out_en=0.
- R6: After a wake from a stop in which the VCO was off, sys_clk stays on ref_clk and lock_ok stays 0 until LOCK_CYC reference rising edges have passed with vco_en=1. After that, sys_clk moves to vco_clk.
- R7: When vco_en=1 in mode 0 and more than LOSS_LIMIT VCO rising edges pass with no reference rising edge, limp_flag goes to 1 and stays 1 until reset.
- R8: On a reference loss with rst_on_loss=0, limp_sel goes to 1 and reset_req stays 0.
- R9: On a reference loss with rst_on_loss=1, reset_req goes to 1 and limp_sel stays 0.
- R10: The source select changes only while the clock gate has been off, and the gate opens only once the incoming source is low.
- R11: While and just after reset, sys_clk, clk_out, e_clk, vco_en, lock_ok, limp_flag, limp_sel and reset_req are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock that oversamples the sources |
| rst_n | input | 1 | Asynchronous active-low reset; the mode pin is sampled while it is low |
| ref_clk | input | 1 | Synthesizer reference clock |
| vco_clk | input | 1 | VCO clock |
| ext_clk | input | 1 | External clock for the direct scheme |
| mode_pin | input | 1 | Scheme select pin (0 = synthesizer, 1 = direct) |
| stop_req | input | 1 | Single-cycle request to enter stop, honoured in ST_RUN |
| wake | input | 1 | Single-cycle wake event, honoured in ST_STOP |
| stop_sys_vco | input | 1 | Keep the VCO as the system clock during stop |
| stop_out_en | input | 1 | Keep clk_out and e_clk toggling during stop |
| rst_on_loss | input | 1 | Reference loss raises reset_req instead of limp mode |
| sys_clk | output | 1 | Gated system clock |
| clk_out | output | 1 | Clock output pin |
| e_clk | output | 1 | Peripheral E-clock |
| vco_enable | output | 1 | Enable for the VCO |
| lock_ok | output | 1 | Relock delay expired while the VCO is enabled |
| limp_flag | output | 1 | Sticky reference-loss status |
| limp_sel | output | 1 | Forces the synthesizer into limp mode |
| reset_req | output | 1 | Device reset request after a reference loss |

## Verification
The hardest condition to reach is the relock window after a stop in which the VCO was switched off. It exists only when the captured mode is 0, stop_sys_vco was 0 at the stop request, and a wake has just arrived. It also lasts only as long as LOCK_CYC reference periods. The stimulus forces this sequence directly and then samples inside the window. It checks that lock_ok is still low and that sys_clk still tracks the reference. Reference loss is reached by stopping the bench's reference generator while the VCO keeps toggling. The bench samples once before and once well after LOSS_LIMIT VCO periods, for each value of rst_on_loss.

// File: rtl/lpc_pkg.sv
`timescale 1ns/1ps
package lpc_pkg;
    localparam int NSRC = 3;

    typedef enum logic [1:0] {
        SRC_REF = 2'd0,
        SRC_VCO = 2'd1,
        SRC_EXT = 2'd2
    } src_e;

    typedef enum logic [2:0] {
        ST_INIT   = 3'd0,
        ST_RELOCK = 3'd1,
        ST_RUN    = 3'd2,
        ST_SW_OFF = 3'd3,
        ST_SW_ON  = 3'd4,
        ST_STOP   = 3'd5
    } ctl_state_e;

    function automatic logic pick_lvl(input logic [NSRC-1:0] v, input src_e s);
        logic r;
        unique case (s)
            SRC_REF: r = v[0];
            SRC_VCO: r = v[1];
            SRC_EXT: r = v[2];
            default: r = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/lpc_level_sampler.sv
`timescale 1ns/1ps
module lpc_level_sampler #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lvl[i] <= 1'b0;
            else        lvl[i] <= raw[i];
        end
    end
endmodule

// File: rtl/lpc_loss_mon.sv
`timescale 1ns/1ps
module lpc_loss_mon #(
    parameter int LOSS_LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic vco_rise,
    input  logic ref_rise,
    output logic lost,
    output logic loss_evt
);
    localparam int CW = $clog2(LOSS_LIMIT + 2);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            lost     <= 1'b0;
            loss_evt <= 1'b0;
        end else begin
            loss_evt <= 1'b0;
            if (!en || ref_rise) begin
                cnt <= '0;
            end else if (vco_rise && !lost) begin
                if (cnt == CW'(LOSS_LIMIT)) begin
                    lost     <= 1'b1;
                    loss_evt <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/lpc_relock_timer.sv
`timescale 1ns/1ps
module lpc_relock_timer #(
    parameter int LOCK_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic ref_rise,
    output logic locked
);
    localparam int CW = $clog2(LOCK_CYC + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  cnt <= '0;
        else if (!run)                               cnt <= '0;
        else if (ref_rise && cnt != CW'(LOCK_CYC))   cnt <= cnt + 1'b1;
    end

    assign locked = run && (cnt == CW'(LOCK_CYC));
endmodule

// File: rtl/lpc_clk_gate.sv
`timescale 1ns/1ps
module lpc_clk_gate
    import lpc_pkg::*;
(
    input  logic [NSRC-1:0] clks,
    input  src_e            sel,
    input  logic            gate_en,
    input  logic            out_en,
    output logic            sys_clk,
    output logic            clk_out,
    output logic            e_clk
);
    logic picked;

    always_comb begin
        unique case (sel)
            SRC_REF: picked = clks[0];
            SRC_VCO: picked = clks[1];
            SRC_EXT: picked = clks[2];
            default: picked = 1'b0;
        endcase
    end

    assign sys_clk = gate_en & picked;
    assign clk_out = sys_clk & out_en;
    assign e_clk   = sys_clk & out_en;
endmodule

// File: rtl/lpc_clk_ctrl.sv
`timescale 1ns/1ps
module lpc_clk_ctrl
    import lpc_pkg::*;
#(
    parameter int LOSS_LIMIT = 64,
    parameter int LOCK_CYC   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    input  logic vco_clk,
    input  logic ext_clk,
    input  logic mode_pin,
    input  logic stop_req,
    input  logic wake,
    input  logic stop_sys_vco,
    input  logic stop_out_en,
    input  logic rst_on_loss,
    output logic sys_clk,
    output logic clk_out,
    output logic e_clk,
    output logic vco_enable,
    output logic lock_ok,
    output logic limp_flag,
    output logic limp_sel,
    output logic reset_req
);
    ctl_state_e      state, state_d, ret_state;
    src_e            sel, tgt;
    logic            gate_en, out_en, out_nxt, vco_nxt;
    logic            mode_lat;
    logic [NSRC-1:0] lvl;
    logic            ref_prev, vco_prev, ref_rise, vco_rise;
    logic            loss_evt;

    // scheme select is captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) mode_lat <= mode_pin;
    end

    lpc_level_sampler #(.W(NSRC)) u_samp (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({ext_clk, vco_clk, ref_clk}),
        .lvl   (lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_prev <= 1'b0;
            vco_prev <= 1'b0;
        end else begin
            ref_prev <= lvl[0];
            vco_prev <= lvl[1];
        end
    end

    assign ref_rise = lvl[0] & ~ref_prev;
    assign vco_rise = lvl[1] & ~vco_prev;

    lpc_loss_mon #(.LOSS_LIMIT(LOSS_LIMIT)) u_loss (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (vco_enable & ~mode_lat),
        .vco_rise (vco_rise),
        .ref_rise (ref_rise),
        .lost     (limp_flag),
        .loss_evt (loss_evt)
    );

    lpc_relock_timer #(.LOCK_CYC(LOCK_CYC)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (vco_enable),
        .ref_rise (ref_rise),
        .locked   (lock_ok)
    );

    lpc_clk_gate u_gate (
        .clks    ({ext_clk, vco_clk, ref_clk}),
        .sel     (sel),
        .gate_en (gate_en),
        .out_en  (out_en),
        .sys_clk (sys_clk),
        .clk_out (clk_out),
        .e_clk   (e_clk)
    );

    // next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            ST_INIT:   state_d = ST_SW_OFF;
            ST_RELOCK: if (lock_ok) state_d = ST_SW_OFF;
            ST_RUN:    if (stop_req) state_d = ST_SW_OFF;
            ST_SW_OFF: if (!pick_lvl(lvl, sel)) state_d = ST_SW_ON;
            ST_SW_ON:  if (!pick_lvl(lvl, tgt)) state_d = ret_state;
            ST_STOP:   if (wake) state_d = ST_SW_OFF;
            default:   state_d = ST_INIT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_INIT;
        else        state <= state_d;
    end

    // control and output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel        <= SRC_REF;
            tgt        <= SRC_REF;
            ret_state  <= ST_RUN;
            gate_en    <= 1'b0;
            out_en     <= 1'b0;
            out_nxt    <= 1'b0;
            vco_nxt    <= 1'b0;
            vco_enable <= 1'b0;
        end else begin
            unique case (state)
                ST_INIT: begin
                    tgt       <= mode_lat ? SRC_EXT : SRC_REF;
                    ret_state <= mode_lat ? ST_RUN : ST_RELOCK;
                    out_nxt   <= 1'b1;
                    vco_nxt   <= ~mode_lat;
                end
                ST_RELOCK: begin
                    if (lock_ok) begin
                        tgt       <= SRC_VCO;
                        ret_state <= ST_RUN;
                        out_nxt   <= 1'b1;
                        vco_nxt   <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (stop_req) begin
                        tgt       <= mode_lat ? SRC_EXT
                                   : (stop_sys_vco ? SRC_VCO : SRC_REF);
                        ret_state <= ST_STOP;
                        out_nxt   <= stop_out_en;
                        vco_nxt   <= ~mode_lat & stop_sys_vco;
                    end
                end
                ST_SW_OFF: begin
                    if (!pick_lvl(lvl, sel)) gate_en <= 1'b0;
                end
                ST_SW_ON: begin
                    if (!pick_lvl(lvl, tgt)) begin
                        sel        <= tgt;
                        gate_en    <= 1'b1;
                        out_en     <= out_nxt;
                        vco_enable <= vco_nxt;
                    end
                end
                ST_STOP: begin
                    if (wake) begin
                        tgt       <= mode_lat ? SRC_EXT
                                   : ((sel == SRC_VCO) ? SRC_VCO : SRC_REF);
                        ret_state <= (mode_lat || sel == SRC_VCO) ? ST_RUN : ST_RELOCK;
                        out_nxt   <= 1'b1;
                        vco_nxt   <= ~mode_lat;
                    end
                end
                default: begin
                    gate_en <= 1'b0;
                end
            endcase
        end
    end

    // response to a reference loss
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limp_sel  <= 1'b0;
            reset_req <= 1'b0;
        end else if (loss_evt) begin
            if (rst_on_loss) reset_req <= 1'b1;
            else             limp_sel  <= 1'b1;
        end
    end
endmodule

// File: rtl/lpc_clk_ctrl_chk.sv
`timescale 1ns/1ps
module lpc_clk_ctrl_chk
    import lpc_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic sys_clk,
    input logic clk_out,
    input logic e_clk,
    input logic vco_enable,
    input logic lock_ok,
    input logic limp_flag,
    input logic limp_sel,
    input logic reset_req,
    input logic mode_lat,
    input src_e sel,
    input logic gate_en
);
    p_ext_no_vco_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_lat |-> !vco_enable);

    p_out_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_out || e_clk) |-> sys_clk);

    p_lock_needs_vco_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lock_ok |-> vco_enable);

    p_limp_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(limp_flag) |-> limp_flag);

    // one response per loss: R8 and R9
    p_loss_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(limp_sel && reset_req));

    p_resp_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (limp_sel || reset_req) |-> limp_flag);

    p_sel_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel != $past(sel)) |-> !$past(gate_en));
endmodule

bind lpc_clk_ctrl lpc_clk_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sys_clk    (sys_clk),
    .clk_out    (clk_out),
    .e_clk      (e_clk),
    .vco_enable (vco_enable),
    .lock_ok    (lock_ok),
    .limp_flag  (limp_flag),
    .limp_sel   (limp_sel),
    .reset_req  (reset_req),
    .mode_lat   (mode_lat),
    .sel        (sel),
    .gate_en    (gate_en)
);

// File: tb/sim_lpc_clk_ctrl.sv
`timescale 1ns/1ps
module sim_lpc_clk_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_clk = 1'b0, vco_clk = 1'b0, ext_clk = 1'b0;
    logic mode_pin = 1'b0, stop_req = 1'b0, wake = 1'b0;
    logic stop_sys_vco = 1'b0, stop_out_en = 1'b0, rst_on_loss = 1'b0;
    logic sys_clk, clk_out, e_clk, vco_enable, lock_ok, limp_flag, limp_sel, reset_req;

    int checks = 0;
    int fails  = 0;
    bit ref_run = 1'b1;
    bit cur_mode = 1'b0;
    int ref_cnt = 0, vco_cnt = 0, ext_cnt = 0;

    always #2.5 clk = ~clk;

    lpc_clk_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .vco_clk(vco_clk), .ext_clk(ext_clk),
        .mode_pin(mode_pin), .stop_req(stop_req), .wake(wake), .stop_sys_vco(stop_sys_vco),
        .stop_out_en(stop_out_en), .rst_on_loss(rst_on_loss), .sys_clk(sys_clk),
        .clk_out(clk_out), .e_clk(e_clk), .vco_enable(vco_enable), .lock_ok(lock_ok),
        .limp_flag(limp_flag), .limp_sel(limp_sel), .reset_req(reset_req)
    );

    // source clocks: ref period 16, vco period 4 (only while enabled), ext period 6
    always @(negedge clk) begin
        if (ref_run) begin
            ref_cnt <= (ref_cnt == 7) ? 0 : ref_cnt + 1;
            if (ref_cnt == 7) ref_clk <= ~ref_clk;
        end else begin
            ref_clk <= 1'b0;
        end
        if (vco_enable) begin
            vco_cnt <= (vco_cnt == 1) ? 0 : vco_cnt + 1;
            if (vco_cnt == 1) vco_clk <= ~vco_clk;
        end else begin
            vco_clk <= 1'b0;
        end
        ext_cnt <= (ext_cnt == 2) ? 0 : ext_cnt + 1;
        if (ext_cnt == 2) ext_clk <= ~ext_clk;
    end

    function automatic int exp_src(bit mode, bit stopped, bit ssv);
        if (mode) return 2;
        if (stopped && !ssv) return 0;
        return 1;
    endfunction

    function automatic bit exp_vco(bit mode, bit stopped, bit ssv);
        return !mode && (!stopped || ssv);
    endfunction

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    task automatic check_bit(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(bit m, bit rol);
        @(posedge clk); #1;
        rst_n = 1'b0; mode_pin = m; rst_on_loss = rol; ref_run = 1'b1;
        cur_mode = m;
        cyc(4);
        check_bit("R11 sys_clk in reset", sys_clk, 1'b0);
        rst_n = 1'b1;
        cyc(1);
        check_bit("R11 outputs idle", sys_clk | clk_out | e_clk | vco_enable | lock_ok, 1'b0);
        check_bit("R11 loss outputs idle", limp_flag | limp_sel | reset_req, 1'b0);
    endtask

    task automatic pulse_stop(bit ssv, bit soe);
        stop_sys_vco = ssv; stop_out_en = soe; stop_req = 1'b1;
        cyc(1);
        stop_req = 1'b0;
        stop_sys_vco = $urandom_range(1); stop_out_en = $urandom_range(1);
    endtask

    task automatic pulse_wake();
        wake = 1'b1;
        cyc(1);
        wake = 1'b0;
    endtask

    // watch 24 cycles: sys_clk against the expected source, pins against sys_clk
    task automatic window(string req, int src, bit outs);
        int bad = 0, badout = 0;
        logic want = 1'b0, lastact = 1'b0, lastout = 1'b0;
        for (int i = 0; i < 24; i++) begin
            @(posedge clk); #1;
            want = (src == 0) ? ref_clk : (src == 1) ? vco_clk : ext_clk;
            if (sys_clk !== want) begin bad++; lastact = sys_clk; end
            if (clk_out !== (outs & want) || e_clk !== (outs & want)) begin
                badout++; lastout = clk_out;
            end
        end
        checks += 2;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s: sys_clk mismatched %0d times, actual=%b expected source %0d level=%b",
                     req, bad, lastact, src, want);
        end
        if (badout != 0) begin
            fails++;
            $display("FAIL R5: output pins mismatched %0d times, actual=%b expected=%b",
                     badout, lastout, outs & want);
        end
    endtask

    task automatic state_check(string req, bit stopped, bit ssv, bit soe);
        window(req, exp_src(cur_mode, stopped, ssv), !stopped || soe);
        check_bit(req, vco_enable, exp_vco(cur_mode, stopped, ssv));
        check_bit(req, lock_ok, exp_vco(cur_mode, stopped, ssv));
        check_bit("R7 no false loss", limp_flag, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));

        // directed: synthesizer scheme, pin changed after reset (R1, R3)
        do_reset(1'b0, 1'b0);
        mode_pin = 1'b1;
        cyc(340);
        state_check("R3", 1'b0, 1'b0, 1'b0);
        window("R1", 1, 1'b1);

        // stop on reference with pins off (R4, R5)
        pulse_stop(1'b0, 1'b0);
        cyc(60);
        state_check("R4", 1'b1, 1'b0, 1'b0);

        // wake: relock window then VCO (R6)
        pulse_wake();
        cyc(100);
        check_bit("R6 lock still low", lock_ok, 1'b0);
        window("R6", 0, 1'b1);
        cyc(300);
        state_check("R6", 1'b0, 1'b0, 1'b0);

        // stop keeping the VCO with pins on (R4, R5)
        pulse_stop(1'b1, 1'b1);
        cyc(60);
        state_check("R4", 1'b1, 1'b1, 1'b1);
        pulse_wake();
        cyc(60);
        state_check("R3", 1'b0, 1'b0, 1'b0);

        // direct scheme, pin changed after reset (R1, R2)
        do_reset(1'b1, 1'b0);
        mode_pin = 1'b0;
        cyc(60);
        state_check("R2", 1'b0, 1'b0, 1'b0);
        pulse_stop(1'b0, 1'b1);
        cyc(60);
        state_check("R2", 1'b1, 1'b0, 1'b1);
        pulse_wake();
        cyc(60);
        pulse_stop(1'b1, 1'b0);
        cyc(60);
        state_check("R2", 1'b1, 1'b1, 1'b0);

        // random mode and stop settings (R1, R2, R3, R4, R5)
        for (int r = 0; r < 6; r++) begin
            do_reset(1'($urandom_range(1)), 1'b0);
            mode_pin = $urandom_range(1);
            cyc(340);
            state_check(cur_mode ? "R2" : "R3", 1'b0, 1'b0, 1'b0);
            for (int k = 0; k < 3; k++) begin
                bit ssv = 1'($urandom_range(1));
                bit soe = 1'($urandom_range(1));
                pulse_stop(ssv, soe);
                cyc(20 + $urandom_range(40));
                state_check(cur_mode ? "R2" : "R4", 1'b1, ssv, soe);
                pulse_wake();
                cyc(340);
                state_check(cur_mode ? "R2" : "R3", 1'b0, 1'b0, 1'b0);
            end
        end

        // reference loss into limp mode (R7, R8)
        do_reset(1'b0, 1'b0);
        cyc(340);
        ref_run = 1'b0;
        cyc(200);
        check_bit("R7 not yet lost", limp_flag, 1'b0);
        cyc(120);
        check_bit("R7 loss flagged", limp_flag, 1'b1);
        check_bit("R8 limp selected", limp_sel, 1'b1);
        check_bit("R8 no reset request", reset_req, 1'b0);
        ref_run = 1'b1;
        cyc(100);
        check_bit("R7 flag sticky", limp_flag, 1'b1);

        // reference loss into reset request (R9)
        do_reset(1'b0, 1'b1);
        cyc(340);
        ref_run = 1'b0;
        cyc(320);
        check_bit("R9 loss flagged", limp_flag, 1'b1);
        check_bit("R9 reset requested", reset_req, 1'b1);
        check_bit("R9 limp not selected", limp_sel, 1'b0);

        report();
    end
endmodule